// File: doc/BRIEF.md
# Hybrid Target-Buffer and History-Counter Branch Predictor

This block sits beside the fetch stage of a pipelined core and guesses, in the same cycle, whether the instruction at the fetch address is a taken branch and where it goes. Two structures feed the guess. The first is a two-way set-associative target buffer with 256 sets that remembers taken branches and their destinations. The second is a 4096-entry table of 2-bit saturating counters. This table is addressed by XOR-ing twelve PC bits with a 12-bit register of recent branch outcomes. A target-buffer hit always predicts taken to the stored destination. When the buffer misses, the direction comes from the counter table and the address falls through to the next sequential word.

When a branch resolves, the pipeline sends back its PC and its real direction and destination. It also sends the history value that was captured when the branch was predicted and a flag that says whether the guess was wrong. The block then trains the counter, updates the target buffer and advances or repairs the history. After a wrong guess it emits a one-cycle redirect with the correct next PC and holds fetch for a fixed 13-cycle recovery window.

Top module: `branch_predictor`

## Requirements
- R1: When `fetch_pc` matches a valid target-buffer entry (set = PC[9:2], tag = PC[31:10]), `pred_taken` is 1 and `pred_target` is the stored destination, combinationally in the same cycle.
- R2: On a target-buffer miss, `pred_taken` is bit 1 of the counter at index PC[13:2] XOR history, and `pred_target` is `fetch_pc + 4`.
- R3: Counters reset to 1 (weakly not-taken). Each resolved branch moves the counter at index `upd_pc[13:2]` XOR `upd_hist` up by one if taken and down by one if not, saturating at 0 and 3. Values 2 and 3 predict taken.
- R4: The history register resets to 0 and is shown on `pred_hist`. A resolution without a mispredict shifts it left by one and puts the resolved direction in bit 0.
- R5: A mispredicted resolution sets the history to `{upd_hist[10:0], upd_taken}` and discards the current value.
- R6: A resolved taken branch that misses the target buffer is written into it. A not-taken branch that misses leaves the buffer unchanged. A not-taken branch that hits invalidates its entry.
- R7: Each set keeps one recency bit. A taken resolution that hits a way marks the other way as the next victim. An allocation fills the victim way and then marks the other way.
- R8: In the cycle after a mispredicted resolution, `redirect_valid` is 1 for exactly one cycle. `redirect_pc` is `upd_target` if the branch was taken, and `upd_pc + 4` if not.
- R9: `fetch_stall` is high for exactly 13 cycles, starting in the cycle after a mispredicted resolution. Another mispredict during the window restarts the full 13 cycles.
- R10: After reset, `redirect_valid` and `fetch_stall` are 0, the history is 0, and every lookup misses the target buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_taken | output | 1 | Predicted direction for `fetch_pc` |
| pred_target | output | 32 | Predicted next fetch address |
| pred_hist | output | 12 | History value at prediction time, to be carried with the branch |
| upd_valid | input | 1 | A branch resolves this cycle |
| upd_pc | input | 32 | Address of the resolving branch |
| upd_taken | input | 1 | Real direction |
| upd_target | input | 32 | Real destination when taken |
| upd_mispredict | input | 1 | The earlier guess was wrong |
| upd_hist | input | 12 | History captured when the branch was predicted |
| redirect_valid | output | 1 | One-cycle pulse that steers fetch after a mispredict |
| redirect_pc | output | 32 | Correct address for the redirect |
| fetch_stall | output | 1 | Fetch is held during recovery |

## Verification
The prediction outputs are combinational, so they are sampled 2 ns after a new `fetch_pc` is applied on the falling edge. A resolution presented on one falling edge is stored at the next rising edge. Its effect on predictions, history, redirect and stall is therefore read at the falling edge that follows, one cycle after stimulus. The stall window is measured by counting falling edges on which `fetch_stall` is high, starting from that first cycle, and the count must be exactly 13. Counter contents are reached only through predictions. Before each such lookup, a mispredicted not-taken resolution with zero history clears the history, so the lookup index is known.

// File: rtl/bp_pkg.sv
// Package: shared helpers for the branch predictor.
// Assumes 2-bit direction counters where the upper bit is the taken vote.
package bp_pkg;

    localparam logic [1:0] CTR_RESET = 2'b01;

    // Saturating step of a 2-bit direction counter.
    function automatic logic [1:0] ctr_next(input logic [1:0] cur, input logic taken);
        if (taken)
            return (cur == 2'b11) ? cur : cur + 2'b01;
        else
            return (cur == 2'b00) ? cur : cur - 2'b01;
    endfunction

    // Direction vote of a counter.
    function automatic logic ctr_taken(input logic [1:0] cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bp_btb.sv
// Module: two-way set-associative branch target buffer.
// Lookup is combinational on (set, tag). Update happens at the clock edge.
// Only taken branches allocate; a not-taken hit invalidates the entry.
// One recency bit per set names the victim way.
// Assumes exactly two ways. Tags and targets are not reset; valid bits are.
module bp_btb #(
    parameter int PC_W  = 32,
    parameter int SET_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SET_W-1:0]          lk_set,
    input  logic [PC_W-SET_W-3:0]     lk_tag,
    output logic                      lk_hit,
    output logic [PC_W-1:0]           lk_target,
    input  logic                      up_valid,
    input  logic [SET_W-1:0]          up_set,
    input  logic [PC_W-SET_W-3:0]     up_tag,
    input  logic                      up_taken,
    input  logic [PC_W-1:0]           up_target
);
    localparam int WAYS  = 2;
    localparam int SETS  = 1 << SET_W;
    localparam int TAG_W = PC_W - SET_W - 2;

    logic [SETS-1:0]   valid_q [WAYS];
    logic [TAG_W-1:0]  tag_q   [WAYS][SETS];
    logic [PC_W-1:0]   tgt_q   [WAYS][SETS];
    logic [SETS-1:0]   lru_q;
    logic [WAYS-1:0]   lk_match;
    logic [WAYS-1:0]   up_match;
    logic              up_hit;
    logic              up_way;
    logic              victim;

    // Per-way tag compare for the lookup port and the update port.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign lk_match[w] = valid_q[w][lk_set] && (tag_q[w][lk_set] == lk_tag);
        assign up_match[w] = valid_q[w][up_set] && (tag_q[w][up_set] == up_tag);
    end

    assign lk_hit    = |lk_match;
    assign lk_target = lk_match[1] ? tgt_q[1][lk_set] : tgt_q[0][lk_set];
    assign up_hit    = |up_match;
    assign up_way    = up_match[1];
    assign victim    = lru_q[up_set];

    // Valid bits and recency bits: allocate, refresh or invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) valid_q[w] <= '0;
            lru_q <= '0;
        end else if (up_valid) begin
            if (up_hit) begin
                if (up_taken) lru_q[up_set] <= ~up_way;
                else          valid_q[up_way][up_set] <= 1'b0;
            end else if (up_taken) begin
                valid_q[victim][up_set] <= 1'b1;
                lru_q[up_set]           <= ~victim;
            end
        end
    end

    // Tag and target storage, written only for taken branches.
    always_ff @(posedge clk) begin
        if (up_valid && up_taken) begin
            if (up_hit) begin
                tgt_q[up_way][up_set] <= up_target;
            end else begin
                tag_q[victim][up_set] <= up_tag;
                tgt_q[victim][up_set] <= up_target;
            end
        end
    end

    // R7
    lru_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && !up_hit) |=> (lru_q[$past(up_set)] != $past(lru_q[up_set])));

    // R6
    no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && !up_hit) |=>
        ({valid_q[1][$past(up_set)], valid_q[0][$past(up_set)]} ==
         $past({valid_q[1][up_set], valid_q[0][up_set]})));

endmodule

// File: rtl/bp_ght.sv
// Module: global history register and the table of 2-bit direction counters.
// The lookup index is the PC bits XOR the live history. The training index is
// the PC bits XOR the checkpoint history that the branch carried.
// Assumes the caller passes PC bits [GHR_W+1:2].
module bp_ght #(
    parameter int GHR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GHR_W-1:0] lk_bits,
    output logic             lk_taken,
    output logic [GHR_W-1:0] ghr,
    input  logic             up_valid,
    input  logic [GHR_W-1:0] up_bits,
    input  logic [GHR_W-1:0] up_hist,
    input  logic             up_taken,
    input  logic             up_misp
);
    localparam int ENTRIES = 1 << GHR_W;

    logic [1:0]       ctr_q [ENTRIES];
    logic [GHR_W-1:0] ghr_q;
    logic [GHR_W-1:0] lk_idx;
    logic [GHR_W-1:0] up_idx;

    assign lk_idx   = lk_bits ^ ghr_q;
    assign up_idx   = up_bits ^ up_hist;
    assign lk_taken = bp_pkg::ctr_taken(ctr_q[lk_idx]);
    assign ghr      = ghr_q;

    // Counter training on every resolved branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= bp_pkg::CTR_RESET;
        end else if (up_valid) begin
            ctr_q[up_idx] <= bp_pkg::ctr_next(ctr_q[up_idx], up_taken);
        end
    end

    // History: shift on a correct guess, rebuild from the checkpoint on a mispredict.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ghr_q <= '0;
        else if (up_valid)
            ghr_q <= up_misp ? {up_hist[GHR_W-2:0], up_taken} : {ghr_q[GHR_W-2:0], up_taken};
    end

    // R4
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_misp) |=> (ghr_q == {$past(ghr_q[GHR_W-2:0]), $past(up_taken)}));

    // R5
    hist_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_misp) |=> (ghr_q == {$past(up_hist[GHR_W-2:0]), $past(up_taken)}));

    // R3
    ctr_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && ctr_q[up_idx] == 2'b11) |=> (ctr_q[$past(up_idx)] == 2'b11));

    // R3
    ctr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && ctr_q[up_idx] == 2'b00) |=> (ctr_q[$past(up_idx)] == 2'b00));

endmodule

// File: rtl/bp_recover.sv
// Module: mispredict recovery. It registers a one-cycle redirect and loads a
// down-counter that holds fetch for PENALTY cycles.
// Assumes at most one resolution per cycle. A new mispredict reloads the count.
module bp_recover #(
    parameter int PC_W    = 32,
    parameter int PENALTY = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            up_valid,
    input  logic            up_misp,
    input  logic            up_taken,
    input  logic [PC_W-1:0] up_pc,
    input  logic [PC_W-1:0] up_target,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc,
    output logic            fetch_stall
);
    localparam int CNT_W = $clog2(PENALTY + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             fire;

    assign fire        = up_valid && up_misp;
    assign fetch_stall = (cnt_q != '0);

    // Redirect pulse and corrected next PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= fire;
            if (fire) redirect_pc <= up_taken ? up_target : up_pc + PC_W'(4);
        end
    end

    // Recovery window counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (fire)     cnt_q <= CNT_W'(PENALTY);
        else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
    end

    // R8
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> redirect_valid);

    // R8
    redirect_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> $past(fire));

    // R9
    stall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cnt_q == CNT_W'(PENALTY)));

    // R9
    stall_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !fire) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/branch_predictor.sv
// Module: fetch-stage branch predictor top. A target-buffer hit predicts taken
// to the stored target. A miss uses the history-indexed counter vote and falls
// through to PC+4. Resolutions train both structures and drive recovery.
// Assumes word-aligned PCs and one resolution per cycle.
module branch_predictor #(
    parameter int PC_W    = 32,
    parameter int SET_W   = 8,
    parameter int GHR_W   = 12,
    parameter int PENALTY = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  fetch_pc,
    output logic             pred_taken,
    output logic [PC_W-1:0]  pred_target,
    output logic [GHR_W-1:0] pred_hist,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic             upd_taken,
    input  logic [PC_W-1:0]  upd_target,
    input  logic             upd_mispredict,
    input  logic [GHR_W-1:0] upd_hist,
    output logic             redirect_valid,
    output logic [PC_W-1:0]  redirect_pc,
    output logic             fetch_stall
);
    localparam int TAG_LO = SET_W + 2;

    logic            btb_hit;
    logic [PC_W-1:0] btb_target;
    logic            ght_taken;

    bp_btb #(.PC_W(PC_W), .SET_W(SET_W)) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_set    (fetch_pc[TAG_LO-1:2]),
        .lk_tag    (fetch_pc[PC_W-1:TAG_LO]),
        .lk_hit    (btb_hit),
        .lk_target (btb_target),
        .up_valid  (upd_valid),
        .up_set    (upd_pc[TAG_LO-1:2]),
        .up_tag    (upd_pc[PC_W-1:TAG_LO]),
        .up_taken  (upd_taken),
        .up_target (upd_target)
    );

    bp_ght #(.GHR_W(GHR_W)) u_ght (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_bits  (fetch_pc[GHR_W+1:2]),
        .lk_taken (ght_taken),
        .ghr      (pred_hist),
        .up_valid (upd_valid),
        .up_bits  (upd_pc[GHR_W+1:2]),
        .up_hist  (upd_hist),
        .up_taken (upd_taken),
        .up_misp  (upd_mispredict)
    );

    bp_recover #(.PC_W(PC_W), .PENALTY(PENALTY)) u_rec (
        .clk            (clk),
        .rst_n          (rst_n),
        .up_valid       (upd_valid),
        .up_misp        (upd_mispredict),
        .up_taken       (upd_taken),
        .up_pc          (upd_pc),
        .up_target      (upd_target),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .fetch_stall    (fetch_stall)
    );

    // Select the prediction: target-buffer hit first, counter vote otherwise.
    always_comb begin
        pred_taken  = btb_hit ? 1'b1 : ght_taken;
        pred_target = btb_hit ? btb_target : fetch_pc + PC_W'(4);
    end

    // R1
    hit_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        btb_hit |-> (pred_taken && pred_target == btb_target));

endmodule

// File: tb/branch_predictor_test.sv
module branch_predictor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken;
    logic [31:0] pred_target;
    logic [11:0] pred_hist;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        upd_mispredict = 1'b0;
    logic [11:0] upd_hist = '0;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic        fetch_stall;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    branch_predictor uut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .pred_target(pred_target), .pred_hist(pred_hist),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_mispredict(upd_mispredict), .upd_hist(upd_hist),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .fetch_stall(fetch_stall)
    );

    typedef struct packed {
        logic        upd;
        logic [31:0] pc;
        logic        taken;
        logic [31:0] tgt;
        logic        misp;
        logic [11:0] hist;
        logic        e_taken;
        logic [31:0] e_tgt;
        logic [11:0] e_hist;
    } vec_t;

    // Main scenario. R1 hit, R2 miss path through the history XOR, R4 history.
    localparam vec_t TBL [8] = '{
        '{1'b0, 32'h1000, 1'b0, 32'h0,    1'b0, 12'h000, 1'b0, 32'h1004, 12'h000},
        '{1'b1, 32'h1000, 1'b1, 32'h2000, 1'b1, 12'h000, 1'b0, 32'h0,    12'h000},
        '{1'b0, 32'h1000, 1'b0, 32'h0,    1'b0, 12'h000, 1'b1, 32'h2000, 12'h001},
        '{1'b0, 32'h1004, 1'b0, 32'h0,    1'b0, 12'h000, 1'b1, 32'h1008, 12'h001},
        '{1'b0, 32'h1400, 1'b0, 32'h0,    1'b0, 12'h000, 1'b0, 32'h1404, 12'h001},
        '{1'b1, 32'h3000, 1'b0, 32'h0,    1'b0, 12'h001, 1'b0, 32'h0,    12'h000},
        '{1'b0, 32'h1004, 1'b0, 32'h0,    1'b0, 12'h000, 1'b0, 32'h1008, 12'h002},
        '{1'b0, 32'h1000, 1'b0, 32'h0,    1'b0, 12'h000, 1'b1, 32'h2000, 12'h002}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_update(input logic [31:0] pc, input logic tk, input logic [31:0] tgt,
                             input logic misp, input logic [11:0] hist);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = tk;
        upd_target = tgt; upd_mispredict = misp; upd_hist = hist;
        @(negedge clk);
        upd_valid = 1'b0; upd_mispredict = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] pc);
        @(negedge clk);
        fetch_pc = pc;
        #2;
    endtask

    // Clears the history to zero through a not-taken mispredict at an unrelated PC.
    task automatic clear_hist();
        do_update(32'h3000, 1'b0, 32'h0, 1'b1, 12'h000);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        lookup(32'h0);
        check("R10 pred_taken", {31'b0, pred_taken}, 32'd0);
        check("R10 pred_target", pred_target, 32'h4);
        check("R10 pred_hist", {20'b0, pred_hist}, 32'h0);
        check("R10 fetch_stall", {31'b0, fetch_stall}, 32'd0);
        check("R10 redirect_valid", {31'b0, redirect_valid}, 32'd0);

        // Vector walk: R1, R2, R4
        for (int i = 0; i < 8; i++) begin
            if (TBL[i].upd) begin
                do_update(TBL[i].pc, TBL[i].taken, TBL[i].tgt, TBL[i].misp, TBL[i].hist);
            end else begin
                lookup(TBL[i].pc);
                check("R1/R2 taken", {31'b0, pred_taken}, {31'b0, TBL[i].e_taken});
                check("R1/R2 target", pred_target, TBL[i].e_tgt);
                check("R4 hist", {20'b0, pred_hist}, {20'b0, TBL[i].e_hist});
            end
        end

        // R3 saturation at the floor: index 0x800 via pc 0x2000 and history 0
        do_update(32'h2000, 1'b0, 32'h0, 1'b0, 12'h000);
        do_update(32'h2000, 1'b0, 32'h0, 1'b0, 12'h000);
        do_update(32'h2000, 1'b1, 32'h2400, 1'b0, 12'h000);
        clear_hist();
        lookup(32'h6000);
        check("R3 floor then one up", {31'b0, pred_taken}, 32'd0);
        check("R2 fallthrough", pred_target, 32'h6004);
        do_update(32'h2000, 1'b1, 32'h2400, 1'b0, 12'h000);
        clear_hist();
        lookup(32'h6000);
        check("R3 threshold two", {31'b0, pred_taken}, 32'd1);
        // R3 saturation at the ceiling
        do_update(32'h2000, 1'b1, 32'h2400, 1'b0, 12'h000);
        do_update(32'h2000, 1'b1, 32'h2400, 1'b0, 12'h000);
        do_update(32'h2000, 1'b1, 32'h2400, 1'b0, 12'h000);
        do_update(32'h2000, 1'b0, 32'h0, 1'b0, 12'h000);
        clear_hist();
        lookup(32'h6000);
        check("R3 ceiling then one down", {31'b0, pred_taken}, 32'd1);

        // R7 recency replacement in set 0x10
        do_update(32'h040, 1'b1, 32'hA00, 1'b0, 12'h000);
        do_update(32'h440, 1'b1, 32'hB00, 1'b0, 12'h000);
        do_update(32'h040, 1'b1, 32'hA00, 1'b0, 12'h000);
        do_update(32'h840, 1'b1, 32'hC00, 1'b0, 12'h000);
        lookup(32'h040);
        check("R7 refreshed way kept", pred_target, 32'hA00);
        lookup(32'h440);
        check("R7 victim evicted", pred_target, 32'h444);
        lookup(32'h840);
        check("R7 new entry taken", {31'b0, pred_taken}, 32'd1);
        check("R7 new entry target", pred_target, 32'hC00);

        // R6 not-taken hit invalidates; not-taken miss does not allocate
        do_update(32'h040, 1'b0, 32'h0, 1'b0, 12'h000);
        lookup(32'h040);
        check("R6 invalidated", pred_target, 32'h044);
        do_update(32'h4C0, 1'b0, 32'h0, 1'b0, 12'h000);
        lookup(32'h4C0);
        check("R6 no allocation", pred_target, 32'h4C4);

        // R5 history restore, then R4 shift from the restored value
        do_update(32'h9000, 1'b1, 32'h9100, 1'b1, 12'hABC);
        lookup(32'h0);
        check("R5 restore", {20'b0, pred_hist}, 32'h579);
        do_update(32'h9200, 1'b0, 32'h0, 1'b0, 12'h579);
        lookup(32'h0);
        check("R4 shift", {20'b0, pred_hist}, 32'hAF2);

        // R8 and R9: wait for idle, then a taken mispredict
        for (int k = 0; k < 20 && fetch_stall; k++) @(negedge clk);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = 32'h5000; upd_taken = 1'b1;
        upd_target = 32'h7000; upd_mispredict = 1'b1; upd_hist = 12'h000;
        @(negedge clk);
        upd_valid = 1'b0; upd_mispredict = 1'b0;
        check("R8 redirect pulse", {31'b0, redirect_valid}, 32'd1);
        check("R8 taken redirect pc", redirect_pc, 32'h7000);
        begin
            int n;
            n = 1;
            @(negedge clk);
            check("R8 single cycle", {31'b0, redirect_valid}, 32'd0);
            while (fetch_stall && n < 40) begin
                n++;
                @(negedge clk);
            end
            check("R9 stall length", n, 32'd13);
        end

        // R8 not-taken mispredict redirects to pc+4; R9 reload mid-window
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = 32'h5100; upd_taken = 1'b0;
        upd_target = 32'h0; upd_mispredict = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0; upd_mispredict = 1'b0;
        check("R8 fallthrough redirect pc", redirect_pc, 32'h5104);
        repeat (4) @(negedge clk);
        upd_valid = 1'b1; upd_pc = 32'h5200; upd_taken = 1'b1;
        upd_target = 32'h5800; upd_mispredict = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0; upd_mispredict = 1'b0;
        begin
            int m;
            m = 0;
            while (fetch_stall && m < 40) begin
                m++;
                @(negedge clk);
            end
            check("R9 reload length", m, 32'd13);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule